// File: doc/BRIEF.md
# K1/K2 Protection Byte Monitor

This block watches the two automatic-protection-switching bytes of a line overhead, K1 and K2, delivered once per frame with a one-cycle frame strobe. A new K1/K2 pair is adopted into a 16-bit validated register only after it has arrived unchanged for three frames in a row. The same byte stream is filtered for four persistent conditions: line AIS and line RDI, both taken from the K2 mode bits; a mismatch between the K2 architecture bit and the K2 mode code; and a protection-byte defect raised when K1 never settles.

Each condition drives a live output. A rising edge of any condition, or a load of the validated register, sets a sticky status bit. Status bits are cleared by writing a one. Each status bit has its own mask, and the interrupt line is the OR of all unmasked status bits. A small register port gives read access to the validated bytes, status, masks, the persistence selection and the live conditions.

Top module: `kmon_top`

## Requirements
- R1: After reset the validated pair is 0x0000. All four conditions are low. Status (address 2) reads 0x00, mask (address 3) reads 0x1F (all masked), config (address 4) reads 0x00, and irq is low.
- R2: A pair {K1,K2} that differs from the validated pair and arrives identically on 3 consecutive strobed frames is loaded on the third frame. K1 goes into bits [15:8] of the validated output and K2 into bits [7:0]. Address 0 reads the validated K1 and address 1 reads the validated K2.
- R3: A pair seen on only 2 consecutive frames is not loaded. Three repeats of the already validated pair leave the new-value status bit clear.
- R4: Loading the validated register sets status bit 0. irq is high exactly when some status bit is 1 and its mask bit (same position) is 0.
- R5: Line AIS (port line_ais) is declared when K2[2:0] = 111 for N consecutive frames. N is 3 when config bit 0 is 0, and 5 when it is 1.
- R6: Line RDI (port line_rdi) is declared when K2[2:0] = 110 for N consecutive frames, with the same N.
- R7: Mode mismatch (port mode_mismatch) is declared when, for N consecutive frames, K2[2:0] is neither 110 nor 111 and differs from {1'b1, 1'b0, K2[3]}.
- R8: AIS, RDI and mode mismatch each drop on the first strobed frame that does not meet their pattern.
- R9: The protection-byte defect (port pbyte_defect) is declared after 12 consecutive frames in which K1 never repeats three times in a row. It clears on the frame that completes a run of 3 identical K1 values.
- R10: Loading new pairs into the validated register continues while line AIS is active.
- R11: Sticky status bits are set on the rising edge of a condition: bit 1 AIS, bit 2 RDI, bit 3 mode mismatch, bit 4 protection-byte defect. Writing 1 to a status bit at address 2 clears it. Writes to address 3 set the masks, and writes to address 4 set the config.
- R12: K1/K2 inputs that are not accompanied by the frame strobe change neither the validated pair nor any condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_vld | input | 1 | One-cycle strobe marking valid K1/K2 for a frame |
| k1_in | input | 8 | Received K1 byte |
| k2_in | input | 8 | Received K2 byte |
| reg_addr | input | 3 | Register address (0 K1, 1 K2, 2 status, 3 mask, 4 config, 5 live) |
| reg_wr | input | 1 | Register write enable |
| reg_wdata | input | 5 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational on reg_addr) |
| k1k2_valid | output | 16 | Validated pair, K1 in [15:8] |
| line_ais | output | 1 | Line AIS condition |
| line_rdi | output | 1 | Line RDI condition |
| mode_mismatch | output | 1 | K2 architecture/mode mismatch condition |
| pbyte_defect | output | 1 | Protection-byte (K1 inconsistency) defect |
| irq | output | 1 | OR of unmasked status bits |

## Verification
The bench probes the frame on which each filter fires: the second frame of a new pair, where a counter off by one would load too early, and the fourth frame of RDI with the 5-frame setting, where a design ignoring the config would already report RDI. It resends the validated pair to catch a design that sets the new-value flag on every completed run. It also sends an AIS run that carries a changing K1, which catches validation being gated by AIS. For the K1 defect it steps through an alternating sequence of 11 and then 12 frames, and follows with two and then three equal bytes. A design that clears the defect on any repeat, or counts the window wrongly, fails there. Unstrobed byte changes and write-one-to-clear with masked bits check the register side.

// File: rtl/kmon_pkg.sv
package kmon_pkg;
    localparam int KW   = 8;          // width of one protection byte
    localparam int PW   = 2 * KW;     // width of the K1/K2 pair
    localparam int AW   = 3;          // register address width
    localparam int ST_W = 5;          // status / mask width
    localparam int NDEF = 4;          // number of filtered conditions

    // status and mask bit positions
    localparam int ST_NEW  = 0;
    localparam int ST_AIS  = 1;
    localparam int ST_RDI  = 2;
    localparam int ST_MISM = 3;
    localparam int ST_PBD  = 4;

    // condition vector positions (status bit = position + 1)
    localparam int DF_AIS  = 0;
    localparam int DF_RDI  = 1;
    localparam int DF_MISM = 2;
    localparam int DF_PBD  = 3;

    localparam logic [2:0] K2_CODE_AIS = 3'b111;
    localparam logic [2:0] K2_CODE_RDI = 3'b110;

    typedef enum logic [AW-1:0] {
        RA_K1   = 3'd0,
        RA_K2   = 3'd1,
        RA_STAT = 3'd2,
        RA_MASK = 3'd3,
        RA_CFG  = 3'd4,
        RA_LIVE = 3'd5
    } reg_addr_e;
endpackage

// File: rtl/kmon_validate.sv
module kmon_validate #(
    parameter int W       = 16,
    parameter int PERSIST = 3,
    localparam int CW     = $clog2(PERSIST + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         frame_vld,
    input  logic [W-1:0] pair_in,
    output logic [W-1:0] valid_o,
    output logic         upd_o
);
    typedef struct packed {
        logic [W-1:0]  cand;
        logic [CW-1:0] run;
        logic [W-1:0]  valid;
        logic          upd;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.upd = 1'b0;
        if (frame_vld) begin
            if (st_q.run != '0 && pair_in == st_q.cand) begin
                if (st_q.run != CW'(PERSIST)) begin
                    st_d.run = st_q.run + 1'b1;
                end
            end else begin
                st_d.cand = pair_in;
                st_d.run  = CW'(1);
            end
            if (st_d.run == CW'(PERSIST) && pair_in != st_q.valid) begin
                st_d.valid = pair_in;
                st_d.upd   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign valid_o = st_q.valid;
    assign upd_o   = st_q.upd;
endmodule

// File: rtl/kmon_persist.sv
module kmon_persist #(
    parameter int MAXN = 5,
    localparam int TW  = $clog2(MAXN + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_vld,
    input  logic          hit,
    input  logic [TW-1:0] thresh,
    output logic          active
);
    typedef struct packed {
        logic [TW-1:0] cnt;
        logic          act;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (frame_vld) begin
            if (hit) begin
                if (st_q.cnt != TW'(MAXN)) begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
                if (st_d.cnt >= thresh) begin
                    st_d.act = 1'b1;
                end
            end else begin
                st_d.cnt = '0;
                st_d.act = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign active = st_q.act;
endmodule

// File: rtl/kmon_k1_incons.sv
module kmon_k1_incons #(
    parameter int W    = 8,
    parameter int RUN  = 3,
    parameter int SPAN = 12,
    localparam int RW  = $clog2(RUN + 1),
    localparam int SW  = $clog2(SPAN + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         frame_vld,
    input  logic [W-1:0] k1_in,
    output logic         defect
);
    typedef struct packed {
        logic [W-1:0]  last;
        logic [RW-1:0] run;
        logic [SW-1:0] win;
        logic          def;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (frame_vld) begin
            if (st_q.run != '0 && k1_in == st_q.last) begin
                if (st_q.run != RW'(RUN)) begin
                    st_d.run = st_q.run + 1'b1;
                end
            end else begin
                st_d.run = RW'(1);
            end
            st_d.last = k1_in;
            if (st_d.run == RW'(RUN)) begin
                st_d.win = '0;
            end else if (st_q.win != SW'(SPAN)) begin
                st_d.win = st_q.win + 1'b1;
            end
            st_d.def = (st_d.win == SW'(SPAN));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign defect = st_q.def;
endmodule

// File: rtl/kmon_regs.sv
module kmon_regs
    import kmon_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   reg_addr,
    input  logic            reg_wr,
    input  logic [ST_W-1:0] reg_wdata,
    input  logic [PW-1:0]   valid_pair,
    input  logic            new_evt,
    input  logic [NDEF-1:0] defects,
    output logic [KW-1:0]   reg_rdata,
    output logic            long_sel,
    output logic [ST_W-1:0] status_o,
    output logic            irq
);
    typedef struct packed {
        logic [ST_W-1:0] status;
        logic [ST_W-1:0] mask;
        logic            long_sel;
        logic [NDEF-1:0] def_prev;
    } st_t;

    st_t st_d, st_q;
    logic [ST_W-1:0] set_vec;

    always_comb begin
        set_vec = {defects & ~st_q.def_prev, new_evt};
        st_d          = st_q;
        st_d.def_prev = defects;
        if (reg_wr) begin
            case (reg_addr_e'(reg_addr))
                RA_STAT: st_d.status   = st_q.status & ~reg_wdata;
                RA_MASK: st_d.mask     = reg_wdata;
                RA_CFG:  st_d.long_sel = reg_wdata[0];
                default: ;
            endcase
        end
        st_d.status = st_d.status | set_vec;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.status   <= '0;
            st_q.mask     <= '1;
            st_q.long_sel <= 1'b0;
            st_q.def_prev <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (reg_addr_e'(reg_addr))
            RA_K1:   reg_rdata = valid_pair[PW-1:KW];
            RA_K2:   reg_rdata = valid_pair[KW-1:0];
            RA_STAT: reg_rdata = KW'(st_q.status);
            RA_MASK: reg_rdata = KW'(st_q.mask);
            RA_CFG:  reg_rdata = KW'(st_q.long_sel);
            RA_LIVE: reg_rdata = KW'({defects, 1'b0});
            default: reg_rdata = '0;
        endcase
    end

    assign long_sel = st_q.long_sel;
    assign status_o = st_q.status;
    assign irq      = |(st_q.status & ~st_q.mask);
endmodule

// File: rtl/kmon_top.sv
module kmon_top
    import kmon_pkg::*;
#(
    parameter int VALID_N = 3,
    parameter int SHORT_N = 3,
    parameter int LONG_N  = 5,
    parameter int K1_RUN  = 3,
    parameter int K1_SPAN = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            frame_vld,
    input  logic [KW-1:0]   k1_in,
    input  logic [KW-1:0]   k2_in,
    input  logic [AW-1:0]   reg_addr,
    input  logic            reg_wr,
    input  logic [ST_W-1:0] reg_wdata,
    output logic [KW-1:0]   reg_rdata,
    output logic [PW-1:0]   k1k2_valid,
    output logic            line_ais,
    output logic            line_rdi,
    output logic            mode_mismatch,
    output logic            pbyte_defect,
    output logic            irq
);
    localparam int PTW = $clog2(LONG_N + 1);
    localparam int NK2 = 3;

    logic            new_evt;
    logic            long_sel;
    logic [PTW-1:0]  thresh;
    logic [NK2-1:0]  k2_hit;
    logic [NDEF-1:0] defects;
    logic [ST_W-1:0] status_vec;

    kmon_validate #(.W(PW), .PERSIST(VALID_N)) u_valid (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_vld (frame_vld),
        .pair_in   ({k1_in, k2_in}),
        .valid_o   (k1k2_valid),
        .upd_o     (new_evt)
    );

    always_comb begin
        thresh             = long_sel ? PTW'(LONG_N) : PTW'(SHORT_N);
        k2_hit[DF_AIS]     = (k2_in[2:0] == K2_CODE_AIS);
        k2_hit[DF_RDI]     = (k2_in[2:0] == K2_CODE_RDI);
        k2_hit[DF_MISM]    = (k2_in[2:0] != K2_CODE_AIS) && (k2_in[2:0] != K2_CODE_RDI)
                             && (k2_in[2:0] != {2'b10, k2_in[3]});
    end

    for (genvar g = 0; g < NK2; g++) begin : g_k2
        kmon_persist #(.MAXN(LONG_N)) u_persist (
            .clk       (clk),
            .rst_n     (rst_n),
            .frame_vld (frame_vld),
            .hit       (k2_hit[g]),
            .thresh    (thresh),
            .active    (defects[g])
        );
    end

    kmon_k1_incons #(.W(KW), .RUN(K1_RUN), .SPAN(K1_SPAN)) u_k1 (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_vld (frame_vld),
        .k1_in     (k1_in),
        .defect    (defects[DF_PBD])
    );

    kmon_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_addr   (reg_addr),
        .reg_wr     (reg_wr),
        .reg_wdata  (reg_wdata),
        .valid_pair (k1k2_valid),
        .new_evt    (new_evt),
        .defects    (defects),
        .reg_rdata  (reg_rdata),
        .long_sel   (long_sel),
        .status_o   (status_vec),
        .irq        (irq)
    );

    assign line_ais      = defects[DF_AIS];
    assign line_rdi      = defects[DF_RDI];
    assign mode_mismatch = defects[DF_MISM];
    assign pbyte_defect  = defects[DF_PBD];
endmodule

// File: rtl/kmon_chk.sv
module kmon_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        frame_vld,
    input logic [7:0]  k2_in,
    input logic [15:0] k1k2_valid,
    input logic        line_ais,
    input logic        line_rdi,
    input logic        mode_mismatch,
    input logic        pbyte_defect,
    input logic [4:0]  status_vec
);
    // R8
    ais_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_vld && k2_in[2:0] != 3'b111) |=> !line_ais);

    // R8
    rdi_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_vld && k2_in[2:0] != 3'b110) |=> !line_rdi);

    // R5
    ais_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(line_ais) |-> ($past(frame_vld) && $past(k2_in[2:0]) == 3'b111));

    // R12
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_vld |=> $stable({k1k2_valid, line_ais, line_rdi, mode_mismatch, pbyte_defect}));

    // R4
    new_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (k1k2_valid != $past(k1k2_valid)) |=> status_vec[0]);

    // R6
    ais_rdi_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(line_ais && line_rdi));
endmodule

bind kmon_top kmon_chk i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .frame_vld     (frame_vld),
    .k2_in         (k2_in),
    .k1k2_valid    (k1k2_valid),
    .line_ais      (line_ais),
    .line_rdi      (line_rdi),
    .mode_mismatch (mode_mismatch),
    .pbyte_defect  (pbyte_defect),
    .status_vec    (status_vec)
);

// File: tb/test_kmon_top.sv
`timescale 1ns/1ps
module test_kmon_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_vld = 1'b0;
    logic [7:0]  k1_in = '0;
    logic [7:0]  k2_in = '0;
    logic [2:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic [15:0] k1k2_valid;
    logic        line_ais, line_rdi, mode_mismatch, pbyte_defect, irq;

    always #2 clk = ~clk;

    kmon_top i_kmon_top (
        .clk(clk), .rst_n(rst_n), .frame_vld(frame_vld),
        .k1_in(k1_in), .k2_in(k2_in),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .k1k2_valid(k1k2_valid),
        .line_ais(line_ais), .line_rdi(line_rdi),
        .mode_mismatch(mode_mismatch), .pbyte_defect(pbyte_defect), .irq(irq)
    );

    // sel: 0 validated pair, 1 conditions {pbd,mism,rdi,ais}, 2 irq, 3 register read
    typedef struct {
        string       req;
        int          sel;
        logic [2:0]  addr;
        logic [15:0] exp;
        logic [15:0] msk;
    } item_t;

    item_t scb[$];
    int    n_checks = 0;
    int    n_errors = 0;
    bit    done = 0;

    task automatic expect_val(input string req, input int sel, input logic [2:0] addr,
                              input logic [15:0] exp, input logic [15:0] msk);
        item_t it;
        it.req = req; it.sel = sel; it.addr = addr; it.exp = exp; it.msk = msk;
        scb.push_back(it);
        wait (scb.size() == 0);
    endtask

    task automatic send(input logic [7:0] a, input logic [7:0] b, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            k1_in = a; k2_in = b; frame_vld = 1'b1;
            @(negedge clk);
            frame_vld = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [4:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
        @(negedge clk);
    endtask

    // monitor: pops expected items and compares with the ports
    initial begin
        forever begin
            @(negedge clk);
            while (scb.size() > 0) begin
                item_t it;
                logic [15:0] got;
                it = scb.pop_front();
                case (it.sel)
                    0: got = k1k2_valid;
                    1: got = {12'h000, pbyte_defect, mode_mismatch, line_rdi, line_ais};
                    2: got = {15'h0000, irq};
                    default: begin
                        reg_addr = it.addr;
                        #1;
                        got = {8'h00, reg_rdata};
                    end
                endcase
                n_checks++;
                if ((got & it.msk) !== (it.exp & it.msk)) begin
                    n_errors++;
                    $display("FAIL %s sel=%0d addr=%0d actual=%h expected=%h",
                             it.req, it.sel, it.addr, got & it.msk, it.exp & it.msk);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        expect_val("R1 valid", 0, 0, 16'h0000, 16'hFFFF);
        expect_val("R1 conds", 1, 0, 16'h0000, 16'hFFFF);
        expect_val("R1 status", 3, 2, 16'h0000, 16'hFFFF);
        expect_val("R1 mask", 3, 3, 16'h001F, 16'hFFFF);
        expect_val("R1 cfg", 3, 4, 16'h0000, 16'hFFFF);
        expect_val("R1 irq", 2, 0, 16'h0000, 16'hFFFF);

        // R2 / R3 / R4 validation
        send(8'h12, 8'h0D, 2);
        expect_val("R3 two frames not loaded", 0, 0, 16'h0000, 16'hFFFF);
        send(8'h12, 8'h0D, 1);
        expect_val("R2 loaded on third frame", 0, 0, 16'h120D, 16'hFFFF);
        expect_val("R2 K1 read", 3, 0, 16'h0012, 16'hFFFF);
        expect_val("R2 K2 read", 3, 1, 16'h000D, 16'hFFFF);
        expect_val("R4 new flag", 3, 2, 16'h0001, 16'h0001);
        expect_val("R4 irq masked", 2, 0, 16'h0000, 16'hFFFF);
        wr(3'd3, 5'h1E);
        expect_val("R4 irq unmasked", 2, 0, 16'h0001, 16'hFFFF);
        wr(3'd2, 5'h01);
        expect_val("R11 status cleared", 3, 2, 16'h0000, 16'hFFFF);
        expect_val("R11 irq after clear", 2, 0, 16'h0000, 16'hFFFF);
        wr(3'd3, 5'h1F);

        // R3 short run and repeat of validated pair
        send(8'h34, 8'h0D, 2);
        send(8'h12, 8'h0D, 1);
        expect_val("R3 short run ignored", 0, 0, 16'h120D, 16'hFFFF);
        send(8'h12, 8'h0D, 2);
        expect_val("R3 repeat no new flag", 3, 2, 16'h0000, 16'hFFFF);

        // R12 unstrobed inputs
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            k1_in = 8'h56 + 8'(i); k2_in = 8'h0F;
        end
        @(negedge clk);
        expect_val("R12 valid unchanged", 0, 0, 16'h120D, 16'hFFFF);
        expect_val("R12 conds unchanged", 1, 0, 16'h0000, 16'hFFFF);

        // R5 AIS with N=3, R10 validation during AIS
        send(8'h12, 8'h07, 2);
        expect_val("R5 AIS not yet", 1, 0, 16'h0000, 16'hFFFF);
        send(8'h12, 8'h07, 1);
        expect_val("R5 AIS declared", 1, 0, 16'h0001, 16'hFFFF);
        expect_val("R11 AIS sticky", 3, 2, 16'h0002, 16'h0002);
        send(8'h55, 8'h07, 3);
        expect_val("R10 load during AIS", 0, 0, 16'h5507, 16'hFFFF);
        expect_val("R10 AIS still on", 1, 0, 16'h0001, 16'hFFFF);
        send(8'h55, 8'h0D, 1);
        expect_val("R8 AIS drops", 1, 0, 16'h0000, 16'hFFFF);
        wr(3'd2, 5'h1F);

        // R5 / R6 RDI with N=5
        wr(3'd4, 5'h01);
        expect_val("R11 cfg write", 3, 4, 16'h0001, 16'hFFFF);
        send(8'h55, 8'h0E, 4);
        expect_val("R5 N=5 RDI not at 4", 1, 0, 16'h0000, 16'hFFFF);
        send(8'h55, 8'h0E, 1);
        expect_val("R6 RDI declared", 1, 0, 16'h0002, 16'hFFFF);
        expect_val("R11 RDI sticky", 3, 2, 16'h0004, 16'h0004);
        expect_val("R11 live read", 3, 5, 16'h0004, 16'hFFFF);
        send(8'h55, 8'h0D, 1);
        expect_val("R8 RDI drops", 1, 0, 16'h0000, 16'hFFFF);

        // R7 mode mismatch with N=3
        wr(3'd4, 5'h00);
        send(8'h55, 8'h05, 2);
        expect_val("R7 mismatch not yet", 1, 0, 16'h0000, 16'hFFFF);
        send(8'h55, 8'h05, 1);
        expect_val("R7 mismatch declared", 1, 0, 16'h0004, 16'hFFFF);
        expect_val("R11 mismatch sticky", 3, 2, 16'h0008, 16'h0008);
        send(8'h55, 8'h04, 1);
        expect_val("R7 consistent code clears", 1, 0, 16'h0000, 16'hFFFF);

        // R9 protection-byte defect
        for (int i = 0; i < 11; i++) send((i % 2 == 0) ? 8'hA0 : 8'hA1, 8'h04, 1);
        expect_val("R9 no defect at 11", 1, 0, 16'h0000, 16'hFFFF);
        send(8'hA1, 8'h04, 1);
        expect_val("R9 defect at 12", 1, 0, 16'h0008, 16'hFFFF);
        expect_val("R11 defect sticky", 3, 2, 16'h0010, 16'h0010);
        wr(3'd3, 5'h0F);
        expect_val("R4 irq from defect", 2, 0, 16'h0001, 16'hFFFF);
        wr(3'd2, 5'h10);
        expect_val("R11 clear one bit", 2, 0, 16'h0000, 16'hFFFF);
        send(8'hA0, 8'h04, 2);
        expect_val("R9 two equal keep defect", 1, 0, 16'h0008, 16'hFFFF);
        send(8'hA0, 8'h04, 1);
        expect_val("R9 run of three clears", 1, 0, 16'h0000, 16'hFFFF);

        #2;
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule